// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for each architectural register, a stored value and a producer tag. A zero tag means the stored value is current. A nonzero tag names the reservation station that will deliver the next value. Each cycle, an in-order issue stage presents two source register numbers. The block answers at once, combinationally. For each source it gives either a current value or the tag of the pending producer. On the clock edge it records the issuing station's tag against the destination register.

The block also listens to the single result broadcast bus. A broadcast (tag, value) writes the value into every register whose pending tag equals the broadcast tag, and those registers become current. A register that was retagged by a younger writer ignores the older producer's broadcast. Write-after-write ordering therefore holds without a stall. A source lookup made in the same cycle as a matching broadcast already returns the broadcast value. Each register entry is a two-state machine: ST_READY (value current) and ST_PENDING (waiting on a tag). Its transitions are:

- ISSUE_CLAIM goes from ST_READY to ST_PENDING when an issue names the register.
- RETAG goes from ST_PENDING to ST_PENDING on an issue, and takes priority over a same-cycle broadcast.
- RESULT_HIT goes from ST_PENDING to ST_READY on a matching broadcast with no issue.
- A mismatching broadcast or an idle cycle holds the state.

Top module: `regstat_table`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves every register current, with value zero and tag zero.
- R2: A lookup of a current register returns ready=1, its stored value, and tag 0.
- R3: A lookup of a pending register returns ready=0 and its producer tag.
- R4: An issue (iss_valid=1, iss_tag nonzero) makes the destination pending on iss_tag from the next cycle on, replacing any earlier pending tag.
- R5: A broadcast (bc_valid=1) whose tag equals a pending register's tag stores bc_value there and makes it current from the next cycle.
- R6: A broadcast whose tag differs from a register's pending tag leaves that register's tag and pending state unchanged.
- R7: A lookup made in the same cycle as a broadcast that matches the looked-up register returns ready=1 and the broadcast value.
- R8: A lookup whose source equals the same cycle's issue destination sees the state from before that issue.
- R9: When an issue and a matching broadcast hit the same register in one cycle, the register ends pending on the new issue tag.
- R10: One broadcast makes current every register pending on its tag, in the same cycle.
- R11: With iss_valid=0, the issue fields change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | IW | First source register number |
| iss_src_b | input | IW | Second source register number |
| iss_dst | input | IW | Destination register number |
| iss_tag | input | TW | Station tag of the issuing instruction (nonzero) |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TW | Tag of the broadcasting station |
| bc_value | input | DW | Broadcast result value |
| src_a_ready | output | 1 | First source value is current |
| src_a_value | output | DW | First source value |
| src_a_tag | output | TW | First source producer tag (0 when ready) |
| src_b_ready | output | 1 | Second source value is current |
| src_b_value | output | DW | Second source value |
| src_b_tag | output | TW | Second source producer tag (0 when ready) |

## Verification
The bench builds the block with its defaults: sixteen registers, 32-bit values and 4-bit tags. With only fifteen usable tags, the random phase often reuses a tag. As a result, several registers end up pending on one station, and old broadcasts arrive after a retag. The directed phase places issue and broadcast in the same cycle on the same register, and also pairs a source with its own destination.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
    typedef enum logic {
        ST_READY   = 1'b0,
        ST_PENDING = 1'b1
    } reg_state_e;
endpackage

// File: rtl/regstat_entry.sv
module regstat_entry
    import regstat_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_issue,
    input  logic [TW-1:0] issue_tag,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_value,
    output logic          pend_o,
    output logic [TW-1:0] tag_o,
    output logic [DW-1:0] value_o
);
    reg_state_e    state_q, state_d;
    logic [TW-1:0] tag_q, tag_d;
    logic [DW-1:0] value_q, value_d;
    logic          bc_hit;

    assign bc_hit = bc_valid && (state_q == ST_PENDING) && (bc_tag == tag_q);

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        value_d = value_q;
        unique case (state_q)
            ST_READY: begin
                if (wr_issue) begin
                    state_d = ST_PENDING;
                    tag_d   = issue_tag;
                end
            end
            ST_PENDING: begin
                if (bc_hit) begin
                    value_d = bc_value;
                end
                if (wr_issue) begin
                    state_d = ST_PENDING;
                    tag_d   = issue_tag;
                end else if (bc_hit) begin
                    state_d = ST_READY;
                    tag_d   = '0;
                end
            end
            default: begin
                state_d = ST_READY;
                tag_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            value_q <= value_d;
        end
    end

    always_comb begin
        pend_o  = (state_q == ST_PENDING);
        tag_o   = tag_q;
        value_o = value_q;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (state_q == ST_READY && tag_q == '0 && value_q == '0));

    assert_issue_claims_R4: assert property (@(posedge clk) disable iff (rst)
        wr_issue |=> (state_q == ST_PENDING && tag_q == $past(issue_tag)));

    assert_result_lands_R5: assert property (@(posedge clk) disable iff (rst)
        (bc_hit && !wr_issue) |=> (state_q == ST_READY && value_q == $past(bc_value)));

    assert_stale_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING && bc_valid && bc_tag != tag_q && !wr_issue)
        |=> (state_q == ST_PENDING && $stable(tag_q) && $stable(value_q)));

    assert_new_tag_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_issue && bc_hit) |=> (state_q == ST_PENDING && tag_q == $past(issue_tag)));

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY && !wr_issue) |=> (state_q == ST_READY && $stable(value_q)));
endmodule

// File: rtl/regstat_lookup.sv
module regstat_lookup #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int TW   = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [IW-1:0]            sel,
    input  logic [NREG-1:0]          pend_vec,
    input  logic [NREG-1:0][TW-1:0]  tag_vec,
    input  logic [NREG-1:0][DW-1:0]  val_vec,
    input  logic                     bc_valid,
    input  logic [TW-1:0]            bc_tag,
    input  logic [DW-1:0]            bc_value,
    output logic                     ready,
    output logic [DW-1:0]            value,
    output logic [TW-1:0]            tag
);
    logic          sel_pend;
    logic [TW-1:0] sel_tag;
    logic [DW-1:0] sel_val;

    always_comb begin
        sel_pend = pend_vec[sel];
        sel_tag  = tag_vec[sel];
        sel_val  = val_vec[sel];
        if (!sel_pend) begin
            ready = 1'b1;
            value = sel_val;
            tag   = '0;
        end else if (bc_valid && bc_tag == sel_tag) begin
            ready = 1'b1;
            value = bc_value;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = sel_val;
            tag   = sel_tag;
        end
    end
endmodule

// File: rtl/regstat_table.sv
module regstat_table #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int TW   = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic [IW-1:0] iss_src_a,
    input  logic [IW-1:0] iss_src_b,
    input  logic [IW-1:0] iss_dst,
    input  logic [TW-1:0] iss_tag,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_value,
    output logic          src_a_ready,
    output logic [DW-1:0] src_a_value,
    output logic [TW-1:0] src_a_tag,
    output logic          src_b_ready,
    output logic [DW-1:0] src_b_value,
    output logic [TW-1:0] src_b_tag
);
    logic [NREG-1:0]         wr_vec;
    logic [NREG-1:0]         pend_vec;
    logic [NREG-1:0][TW-1:0] tag_vec;
    logic [NREG-1:0][DW-1:0] val_vec;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign wr_vec[r] = iss_valid && (iss_dst == IW'(r));
        regstat_entry #(.DW(DW), .TW(TW)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .wr_issue (wr_vec[r]),
            .issue_tag(iss_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .pend_o   (pend_vec[r]),
            .tag_o    (tag_vec[r]),
            .value_o  (val_vec[r])
        );
    end

    regstat_lookup #(.NREG(NREG), .DW(DW), .TW(TW)) u_look_a (
        .sel(iss_src_a), .pend_vec(pend_vec), .tag_vec(tag_vec), .val_vec(val_vec),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .ready(src_a_ready), .value(src_a_value), .tag(src_a_tag)
    );

    regstat_lookup #(.NREG(NREG), .DW(DW), .TW(TW)) u_look_b (
        .sel(iss_src_b), .pend_vec(pend_vec), .tag_vec(tag_vec), .val_vec(val_vec),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .ready(src_b_ready), .value(src_b_value), .tag(src_b_tag)
    );

    assert_issue_tag_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_tag != '0));

    assert_pending_has_tag_R3: assert property (@(posedge clk) disable iff (rst)
        (!src_a_ready) |-> (src_a_tag != '0));
endmodule

// File: tb/regstat_table_bench.sv
`timescale 1ns/1ps
module regstat_table_bench;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int TW   = 4;
    localparam int IW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic [IW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [TW-1:0] iss_tag = '0;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_value = '0;
    logic          src_a_ready, src_b_ready;
    logic [DW-1:0] src_a_value, src_b_value;
    logic [TW-1:0] src_a_tag, src_b_tag;

    always #2.5 clk = ~clk;

    regstat_table #(.NREG(NREG), .DW(DW), .TW(TW)) u_regstat_table (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag)
    );

    typedef struct packed {
        logic          ra;
        logic [DW-1:0] va;
        logic [TW-1:0] ta;
        logic          rb;
        logic [DW-1:0] vb;
        logic [TW-1:0] tb;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    logic          m_pend [NREG];
    logic [TW-1:0] m_tag  [NREG];
    logic [DW-1:0] m_val  [NREG];

    task automatic look(input int s, output logic r, output logic [DW-1:0] v,
                        output logic [TW-1:0] t, input logic bv, input logic [TW-1:0] bt,
                        input logic [DW-1:0] bd);
        if (!m_pend[s]) begin r = 1; v = m_val[s]; t = '0; end
        else if (bv && bt == m_tag[s]) begin r = 1; v = bd; t = '0; end
        else begin r = 0; v = '0; t = m_tag[s]; end
    endtask

    task automatic step(input logic iv, input int sa, input int sb, input int d,
                        input int it, input logic bv, input int bt, input logic [DW-1:0] bd,
                        input string req);
        exp_t e;
        @(negedge clk);
        iss_valid = iv; iss_src_a = IW'(sa); iss_src_b = IW'(sb); iss_dst = IW'(d);
        iss_tag = TW'(it); bc_valid = bv; bc_tag = TW'(bt); bc_value = bd;
        look(sa, e.ra, e.va, e.ta, bv, TW'(bt), bd);
        look(sb, e.rb, e.vb, e.tb, bv, TW'(bt), bd);
        exp_q.push_back(e);
        req_q.push_back(req);
        for (int r = 0; r < NREG; r++) begin
            if (bv && m_pend[r] && m_tag[r] == TW'(bt)) begin
                m_pend[r] = 0; m_val[r] = bd; m_tag[r] = '0;
            end
        end
        if (iv) begin m_pend[d] = 1; m_tag[d] = TW'(it); end
    endtask

    initial begin : monitor
        exp_t e;
        string q;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                q = req_q.pop_front();
                total++;
                if (src_a_ready !== e.ra || src_a_tag !== e.ta ||
                    (e.ra && src_a_value !== e.va)) begin
                    bad++;
                    $display("FAIL %s port a: got r=%0b v=%h t=%0d exp r=%0b v=%h t=%0d",
                             q, src_a_ready, src_a_value, src_a_tag, e.ra, e.va, e.ta);
                end
                total++;
                if (src_b_ready !== e.rb || src_b_tag !== e.tb ||
                    (e.rb && src_b_value !== e.vb)) begin
                    bad++;
                    $display("FAIL %s port b: got r=%0b v=%h t=%0d exp r=%0b v=%h t=%0d",
                             q, src_b_ready, src_b_value, src_b_tag, e.rb, e.vb, e.tb);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        logic [15:0] lfsr = 16'hACE1;
        for (int r = 0; r < NREG; r++) begin m_pend[r] = 0; m_tag[r] = '0; m_val[r] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: every register current and zero after reset
        step(0, 0, 15, 0, 0, 0, 0, '0, "R1");
        step(0, 7, 3, 0, 0, 0, 0, '0, "R1");
        // R8: own destination read as pre-issue state
        step(1, 2, 2, 2, 3, 0, 0, '0, "R8");
        // R7: same-cycle broadcast bypass
        step(0, 2, 5, 0, 0, 1, 3, 32'h1111_1111, "R7");
        // R2 and R5: written value now current
        step(0, 2, 2, 0, 0, 0, 0, '0, "R2_R5");
        // R3 and R4
        step(1, 0, 0, 4, 5, 0, 0, '0, "R4");
        step(1, 4, 4, 4, 6, 0, 0, '0, "R3");
        step(0, 4, 2, 0, 0, 0, 0, '0, "R4_retag");
        // R6: stale producer broadcast dropped
        step(0, 4, 4, 0, 0, 1, 5, 32'hDEAD_0000, "R6");
        step(0, 4, 4, 0, 0, 0, 0, '0, "R6");
        step(0, 4, 4, 0, 0, 1, 6, 32'hBEEF_0000, "R6_latest");
        step(0, 4, 2, 0, 0, 0, 0, '0, "R5");
        // R9: issue beats same-cycle clearing broadcast
        step(1, 0, 0, 7, 1, 0, 0, '0, "R9");
        step(1, 7, 7, 7, 2, 1, 1, 32'h0000_7777, "R9");
        step(0, 7, 7, 0, 0, 0, 0, '0, "R9");
        step(0, 7, 7, 0, 0, 1, 2, 32'h0000_8888, "R9");
        // R10: one broadcast lands in several registers
        step(1, 0, 0, 8, 9, 0, 0, '0, "R10");
        step(1, 8, 8, 9, 9, 0, 0, '0, "R10");
        step(0, 8, 9, 0, 0, 1, 9, 32'h0000_9999, "R10");
        step(0, 8, 9, 0, 0, 0, 0, '0, "R10");
        // R11: fields without iss_valid leave registers unchanged
        step(0, 2, 11, 2, 7, 0, 0, '0, "R11");
        step(0, 2, 11, 11, 7, 0, 0, '0, "R11");
        step(0, 2, 11, 0, 0, 0, 0, '0, "R11");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int it, bt;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            it = int'(lfsr[3:0]) == 0 ? 1 : int'(lfsr[3:0]);
            bt = int'(lfsr[15:12]);
            step(lfsr[4], int'(lfsr[8:5]), int'(lfsr[12:9]), int'(lfsr[11:8]), it,
                 lfsr[6], bt, {lfsr, ~lfsr}, "R2_R10_mix");
        end
        @(negedge clk);
        iss_valid = 0; bc_valid = 0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule